// File: doc/BRIEF.md
# Processor Condition Flag Unit

This block produces and stores the four condition flags of a processor status word: negative (N), zero (Z), carry (C) and overflow (V). After every executed operation the datapath presents the operation's result, the arithmetic carry or borrow, the sign bits of the two operands, the shifter's last bit out and a two-bit operation class. When the update enable is high, the block derives new flag values from these inputs and registers them on the next rising clock edge.

The flags do not all follow the same rule. N and Z always follow the result. C and V follow the operation class. Add and subtract set both C and V. A shifted logical operation takes C from the shifter and keeps V. An unshifted logical operation keeps both C and V.

A separate write port loads all four flags in one cycle, for example when a saved status word is restored. This write takes precedence over an arithmetic update in the same cycle. The ALU, the shifter and instruction decode sit outside this block.

Top module: `cflag_unit`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears N, Z, C and V to 0. The flags are registered and change only at a rising clock edge.
- R2: On an update, N takes the most significant bit (bit DATA_W-1) of the result.
- R3: On an update, Z is 1 when every bit of the result is 0, and 0 otherwise.
- R4: On an update with op_class = 2'b00 (add, which includes compare-negative), C takes arith_cy. For this class, arith_cy is the carry out of the top bit.
- R5: On an update with op_class = 2'b01 (subtract, which includes compare), arith_cy is the unsigned borrow, and C takes its inverse: C = 0 when a borrow occurred and C = 1 otherwise.
- R6: On an update with op_class = 2'b10 (logical with shift), C takes shift_cy, the last bit shifted out.
- R7: On an update with op_class = 2'b11 (logical without shift), C keeps its previous value.
- R8: On an update with op_class 2'b00 or 2'b01, V reports signed overflow.
  - For add, V = 1 when sign_a equals sign_b and the result's top bit differs from sign_a.
  - For subtract, V = 1 when sign_a differs from sign_b and the result's top bit differs from sign_a.
  - In all other add or subtract cases V = 0.
- R9: On an update with op_class 2'b10 or 2'b11, V keeps its previous value.
- R10: When upd_en and wr_en are both low, all four flags keep their values whatever the other inputs do.
- R11: When wr_en is high, the four flags load wr_flags in the bit order {N,Z,C,V} = wr_flags[3:0]. This write overrides an update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Update flags from the current operation |
| op_class | input | 2 | 00 add, 01 subtract, 10 logical with shift, 11 logical without shift |
| result | input | DATA_W | Result of the operation |
| arith_cy | input | 1 | Carry out (add) or borrow (subtract) |
| sign_a | input | 1 | Sign bit of the first operand |
| sign_b | input | 1 | Sign bit of the second operand |
| shift_cy | input | 1 | Last bit shifted out by the shifter |
| wr_en | input | 1 | Direct load of all four flags |
| wr_flags | input | 4 | Flag values to load, {N,Z,C,V} |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The assertions take for granted that every input holds a defined value at each rising edge once reset has been released. They also assume that reset is asserted at the first edge, so that no check ever compares against an uninitialised flag. Beyond that, they treat arith_cy, the sign bits and the result as free inputs: the overflow checks relate V only to the signs actually presented, and they do not need the result to be a genuine sum.

The bench goes further than the assertions require. It derives the result, carry or borrow and the sign bits from real operand pairs, so that each flag outcome matches true two's-complement arithmetic. It also drives every input from the first edge onward.

// File: rtl/cflag_pkg.sv
package cflag_pkg;
  typedef enum logic [1:0] {
    OPC_ADD = 2'b00,
    OPC_SUB = 2'b01,
    OPC_LSH = 2'b10,
    OPC_LNS = 2'b11
  } opc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int FLAG_W = $bits(nzcv_t);
endpackage

// File: rtl/cflag_nz.sv
module cflag_nz #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] result,
  output logic              n_next,
  output logic              z_next
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    n_next = result[MSB];
    z_next = (result == '0);
  end
endmodule

// File: rtl/cflag_carry.sv
module cflag_carry
  import cflag_pkg::*;
(
  input  opc_e op,
  input  logic arith_cy,
  input  logic shift_cy,
  input  logic c_prev,
  output logic c_next
);
  always_comb begin
    unique case (op)
      OPC_ADD: c_next = arith_cy;
      OPC_SUB: c_next = ~arith_cy;   // carry is not-borrow
      OPC_LSH: c_next = shift_cy;
      default: c_next = c_prev;
    endcase
  end
endmodule

// File: rtl/cflag_ovf.sv
module cflag_ovf
  import cflag_pkg::*;
(
  input  opc_e op,
  input  logic sign_a,
  input  logic sign_b,
  input  logic sign_r,
  input  logic v_prev,
  output logic v_next
);
  logic res_flip;
  always_comb begin
    res_flip = sign_r ^ sign_a;
    unique case (op)
      OPC_ADD: v_next = ~(sign_a ^ sign_b) & res_flip;
      OPC_SUB: v_next =  (sign_a ^ sign_b) & res_flip;
      default: v_next = v_prev;
    endcase
  end
endmodule

// File: rtl/cflag_unit.sv
module cflag_unit
  import cflag_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [1:0]        op_class,
  input  logic [DATA_W-1:0] result,
  input  logic              arith_cy,
  input  logic              sign_a,
  input  logic              sign_b,
  input  logic              shift_cy,
  input  logic              wr_en,
  input  logic [3:0]        wr_flags,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v
);
  localparam int MSB = DATA_W - 1;

  opc_e  op;
  nzcv_t flags_q;
  nzcv_t flags_d;

  assign op = opc_e'(op_class);

  cflag_nz #(.DATA_W(DATA_W)) u_nz (
    .result (result),
    .n_next (flags_d.n),
    .z_next (flags_d.z)
  );

  cflag_carry u_carry (
    .op       (op),
    .arith_cy (arith_cy),
    .shift_cy (shift_cy),
    .c_prev   (flags_q.c),
    .c_next   (flags_d.c)
  );

  cflag_ovf u_ovf (
    .op     (op),
    .sign_a (sign_a),
    .sign_b (sign_b),
    .sign_r (result[MSB]),
    .v_prev (flags_q.v),
    .v_next (flags_d.v)
  );

  // Write port outranks arithmetic update.
  always_ff @(posedge clk) begin
    if (rst)         flags_q <= '0;
    else if (wr_en)  flags_q <= nzcv_t'(wr_flags);
    else if (upd_en) flags_q <= flags_d;
  end

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

  // ---------------- assertions ----------------
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000));

  p_neg_msb_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $past(upd_en))
      |-> (flag_n == $past(result[MSB])));

  p_zero_all_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $past(upd_en))
      |-> (flag_z == ($past(result) == '0)));

  p_carry_add_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $past(upd_en) && $past(op_class) == 2'b00)
      |-> (flag_c == $past(arith_cy)));

  p_carry_sub_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $past(upd_en) && $past(op_class) == 2'b01)
      |-> (flag_c != $past(arith_cy)));

  p_carry_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $past(upd_en) && $past(op_class) == 2'b10)
      |-> (flag_c == $past(shift_cy)));

  p_carry_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $past(upd_en) && $past(op_class) == 2'b11)
      |-> $stable(flag_c));

  p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $past(upd_en) && $past(op_class) == 2'b00
     && $past(sign_a) == $past(sign_b) && $past(result[MSB]) != $past(sign_a))
      |-> flag_v);

  p_ovf_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $past(upd_en) && !$past(op_class[1])
     && $past(result[MSB]) == $past(sign_a))
      |-> !flag_v);

  p_ovf_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && $past(upd_en) && $past(op_class[1]))
      |-> $stable(flag_v));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en) && !$past(upd_en))
      |-> $stable({flag_n, flag_z, flag_c, flag_v}));

  p_direct_load_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en))
      |-> ({flag_n, flag_z, flag_c, flag_v} == $past(wr_flags)));
endmodule

// File: tb/cflag_unit_tb.sv
`timescale 1ns/1ps
module cflag_unit_tb;
  localparam int W = 32;
  localparam int NV = 14;
  localparam int VW = 2 + W + W + 1 + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_en = 1'b0;
  logic [1:0] op_class = 2'b00;
  logic [W-1:0] result = '0;
  logic arith_cy = 1'b0, sign_a = 1'b0, sign_b = 1'b0, shift_cy = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_flags = 4'h0;
  logic flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cflag_unit #(.DATA_W(W)) u_dut (
    .clk(clk), .rst(rst), .upd_en(upd_en), .op_class(op_class),
    .result(result), .arith_cy(arith_cy), .sign_a(sign_a), .sign_b(sign_b),
    .shift_cy(shift_cy), .wr_en(wr_en), .wr_flags(wr_flags),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  // {op, a, b, shift_cy, expected NZCV}
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'b00, 32'h0000_0001, 32'h0000_0001, 1'b0, 4'b0000}, // R4 no carry
    {2'b00, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 4'b0110}, // R3 R4 wrap to zero
    {2'b00, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 4'b1001}, // R2 R8 add overflow
    {2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0, 4'b0111}, // R8 neg overflow
    {2'b01, 32'h0000_0005, 32'h0000_0003, 1'b0, 4'b0010}, // R5 no borrow
    {2'b01, 32'h0000_0003, 32'h0000_0005, 1'b0, 4'b1000}, // R5 borrow
    {2'b01, 32'h8000_0000, 32'h0000_0001, 1'b0, 4'b0011}, // R8 sub overflow
    {2'b01, 32'h0000_0007, 32'h0000_0007, 1'b0, 4'b0110}, // R3 equal compare
    {2'b11, 32'hF000_0000, 32'h8000_0000, 1'b0, 4'b1010}, // R7 R9 hold C,V
    {2'b10, 32'h0000_000F, 32'h0000_00F0, 1'b0, 4'b0100}, // R6 shift C=0
    {2'b10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 4'b1010}, // R6 shift C=1
    {2'b01, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 4'b1001}, // R5 R8
    {2'b11, 32'h0000_0001, 32'h0000_0001, 1'b1, 4'b0001}, // R7 R9 hold
    {2'b10, 32'h0000_0000, 32'h0000_0000, 1'b1, 4'b0111}  // R6 R9
  };

  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {flag_n, flag_z, flag_c, flag_v};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: NZCV actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Drive one operation at the falling edge, let one rising edge pass.
  task automatic apply(input logic [1:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic sh,
                       input logic upd, input logic wr, input logic [3:0] wf);
    logic [W:0] sum;
    @(negedge clk);
    op_class = op;
    unique case (op)
      2'b00: begin sum = {1'b0, a} + {1'b0, b}; result = sum[W-1:0]; arith_cy = sum[W]; end
      2'b01: begin result = a - b; arith_cy = (a < b); end
      default: begin result = a & b; arith_cy = 1'b0; end
    endcase
    sign_a = a[W-1];
    sign_b = b[W-1];
    shift_cy = sh;
    upd_en = upd;
    wr_en = wr;
    wr_flags = wf;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset state", 4'b0000);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      apply(v[VW-1 -: 2], v[VW-3 -: W], v[VW-3-W -: W], v[4], 1'b1, 1'b0, 4'h0);
      check($sformatf("vector %0d (R2..R9)", i), v[3:0]);
    end

    // R10: idle cycle with a stimulus that would change every flag
    apply(2'b01, 32'h0000_0000, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 4'h0);
    check("R10 hold while upd_en low", 4'b0111);
    apply(2'b10, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b0, 4'h0);
    check("R10 hold second idle", 4'b0111);

    // R11: direct write wins over a simultaneous update (update would give 0100)
    apply(2'b00, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1, 1'b1, 4'b1010);
    check("R11 write beats update", 4'b1010);
    apply(2'b11, 32'h0000_0001, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 4'b0101);
    check("R11 write alone", 4'b0101);

    // R7 R9: unshifted logical keeps written C=0, V=1
    apply(2'b11, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 4'h0);
    check("R7 R9 keep after write", 4'b1001);

    // R1: reset mid-run clears flags
    @(negedge clk);
    rst = 1'b1;
    upd_en = 1'b0;
    wr_en = 1'b0;
    @(posedge clk);
    #1;
    check("R1 reset mid-run", 4'b0000);
    @(negedge clk);
    rst = 1'b0;
    apply(2'b00, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 4'h0);
    check("R3 zero after reset", 4'b0100);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule